// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block gathers four interrupt sources for a display controller and holds them in one sticky raw status word. The four sources are a bus master error, a vertical timing region compare, a next-base-address update and a merged FIFO underflow. Other blocks supply single-cycle event pulses: the frame timing generator, the two DMA address loaders, the two panel FIFOs and the bus master. A bit that an event has set stays set until software writes a one to it over a small synchronous register bus. A single interrupt output is high while any status bit is set.

The vertical compare source follows one of four frame timing regions. A 2-bit select input picks the region. The timing generator supplies one entry pulse per region, and only the pulse of the selected region sets the bit. The underflow bit merges the upper-panel and lower-panel underflow events. The next-base bit merges the upper and lower base-transfer events.

Top module: `disp_irq_unit`

## Requirements
- R1: While `rst` is high, and on the first sampling after it falls, the status word is 0, `irq` is 0 and `reg_rdata` is 0.
- R2: A read strobe at offset 0x20 returns the status word on `reg_rdata` in the cycle after the strobe. The word holds the value it had before that clock edge. In every other cycle, including after a read at any other offset, `reg_rdata` is 0.
- R3: A write at offset 0x20 clears each status bit whose data bit (4..1) is 1. Bits written with 0 keep their value. A write at any other offset changes nothing.
- R4: Bits 31:5 and bit 0 of the status word always read 0. Writing ones to them has no effect on any status bit.
- R5: A pulse on `ev_bus_err` sets bit 4. The bit stays set until software clears it.
- R6: Bit 3 sets when `rgn_start[rgn_sel]` pulses. The encoding of `rgn_sel` is 0 = vertical sync, 1 = back porch, 2 = active video, 3 = front porch. Entry pulses for regions that are not selected have no effect.
- R7: Bit 1 sets on a pulse of `ev_uf_upper`, of `ev_uf_lower`, or of both.
- R8: Bit 2 sets on a pulse of `ev_base_upper`, of `ev_base_lower`, or of both.
- R9: If a set event and a write-one clear reach the same bit in the same cycle, the bit ends up set.
- R10: `irq` is high in exactly the cycles in which at least one status bit is set. It changes on the same clock edge as the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_bus_err | input | 1 | Bus master received an ERROR response |
| rgn_start | input | 4 | Entry pulses for the frame regions, indexed by region code |
| rgn_sel | input | 2 | Region chosen for the vertical compare |
| ev_base_upper | input | 1 | Upper base address moved into its current counter |
| ev_base_lower | input | 1 | Lower base address moved into its current counter |
| ev_uf_upper | input | 1 | Upper panel FIFO read while empty |
| ev_uf_lower | input | 1 | Lower panel FIFO read while empty |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Write data (write-one-to-clear) |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets these corner cases:
- A set event and a clear arrive on the same bit in the same cycle. A design that lets the clear win drops the event, and `irq` falls.
- Entry pulses arrive for regions other than the selected one, across all four select values. A design that decodes the select wrongly, or ORs all the regions, sets the compare bit at the wrong moments.
- Writes carry ones in the reserved positions, or go to a neighbouring offset. A design with a wrong decode or a shifted field clears bits it should keep.
- Reads come back to back and at other offsets. These expose read data that is late, held over or not cleared, and a status field placed one bit off.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int IRQ_NUM = 4;
  localparam int IRQ_LSB = 1;

  localparam int BIT_FUF   = 0;
  localparam int BIT_NBASE = 1;
  localparam int BIT_VCMP  = 2;
  localparam int BIT_BERR  = 3;

  typedef enum logic [1:0] {
    RGN_SYNC   = 2'd0,
    RGN_BACK   = 2'd1,
    RGN_ACTIVE = 2'd2,
    RGN_FRONT  = 2'd3
  } rgn_code_e;

  typedef struct packed {
    logic berr;
    logic vcmp;
    logic nbase;
    logic fuf;
  } irq_vec_t;
endpackage

// File: rtl/disp_irq_merge.sv
module disp_irq_merge #(
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0] ev_i,
  output logic             hit_o
);
  assign hit_o = |ev_i;
endmodule

// File: rtl/disp_irq_vcmp.sv
module disp_irq_vcmp #(
  parameter int NUM_RGN = 4,
  localparam int SEL_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic [NUM_RGN-1:0] rgn_start_i,
  input  logic [SEL_W-1:0]   rgn_sel_i,
  output logic               hit_o
);
  logic [NUM_RGN-1:0] match;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    assign match[g] = rgn_start_i[g] && (rgn_sel_i == SEL_W'(g));
  end

  assign hit_o = |match;
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] status_q;
  logic [N-1:0] status_nxt;
  logic         irq_q;

  always_comb begin
    status_nxt = (status_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_nxt;
      irq_q    <= |status_nxt;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  for (genvar b = 0; b < N; b++) begin : g_chk
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
      set_i[b] |=> status_q[b]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (clr_i[b] && !set_i[b]) |=> !status_q[b]);
    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[b] && !set_i[b]) |=> $stable(status_q[b]));
  end

  assert_irq_tracks_R10: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|status_q));
endmodule

// File: rtl/disp_irq_regif.sv
module disp_irq_regif #(
  parameter int              ADDR_W = 8,
  parameter int              DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS  = 8'h20,
  parameter int              LSB    = 1,
  parameter int              N      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(((1 << N) - 1) << LSB);

  logic              hit;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] rdata_q;

  assign hit   = (addr_i == OFS);
  assign clr_o = (wr_i && hit) ? wdata_i[LSB +: N] : '0;

  always_comb begin
    word = '0;
    word[LSB +: N] = status_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= (rd_i && hit) ? word : '0;
  end

  assign rdata_o = rdata_q;

  assert_read_miss_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !(rd_i && hit) |=> (rdata_q == '0));
  assert_read_value_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_i && hit) |=> (rdata_q[LSB +: N] == $past(status_i)));
  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rdata_q & ~FIELD_MASK) == '0);
endmodule

// File: rtl/disp_irq_unit.sv
module disp_irq_unit #(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h20,
  parameter int                NUM_RGN    = 4,
  localparam int               SEL_W      = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_bus_err,
  input  logic [NUM_RGN-1:0] rgn_start,
  input  logic [SEL_W-1:0]  rgn_sel,
  input  logic              ev_base_upper,
  input  logic              ev_base_lower,
  input  logic              ev_uf_upper,
  input  logic              ev_uf_lower,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import disp_irq_pkg::*;

  irq_vec_t                set_v;
  logic [IRQ_NUM-1:0]      clr_v;
  logic [IRQ_NUM-1:0]      status_v;
  logic                    vcmp_hit;
  logic                    base_hit;
  logic                    uf_hit;

  disp_irq_vcmp #(.NUM_RGN(NUM_RGN)) u_vcmp (
    .rgn_start_i(rgn_start),
    .rgn_sel_i  (rgn_sel),
    .hit_o      (vcmp_hit)
  );

  disp_irq_merge #(.N_SRC(2)) u_base (
    .ev_i ({ev_base_upper, ev_base_lower}),
    .hit_o(base_hit)
  );

  disp_irq_merge #(.N_SRC(2)) u_uf (
    .ev_i ({ev_uf_upper, ev_uf_lower}),
    .hit_o(uf_hit)
  );

  always_comb begin
    set_v       = '0;
    set_v.berr  = ev_bus_err;
    set_v.vcmp  = vcmp_hit;
    set_v.nbase = base_hit;
    set_v.fuf   = uf_hit;
  end

  disp_irq_status #(.N(IRQ_NUM)) u_status (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .status_o(status_v),
    .irq_o   (irq)
  );

  disp_irq_regif #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFS   (STATUS_OFS),
    .LSB   (IRQ_LSB),
    .N     (IRQ_NUM)
  ) u_regif (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr),
    .rd_i    (reg_rd),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .status_i(status_v),
    .clr_o   (clr_v),
    .rdata_o (reg_rdata)
  );

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(set_v != '0));
  assert_berr_sets_R5: assert property (@(posedge clk) disable iff (rst)
    ev_bus_err |=> status_v[BIT_BERR]);
  assert_uf_merge_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_uf_upper || ev_uf_lower) |=> status_v[BIT_FUF]);
  assert_base_merge_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_base_upper || ev_base_lower) |=> status_v[BIT_NBASE]);
  assert_vcmp_select_R6: assert property (@(posedge clk) disable iff (rst)
    rgn_start[rgn_sel] |=> status_v[BIT_VCMP]);
endmodule

// File: tb/disp_irq_unit_tb.sv
module disp_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_bus_err = 1'b0;
  logic [3:0]  rgn_start = '0;
  logic [1:0]  rgn_sel = '0;
  logic        ev_base_upper = 1'b0;
  logic        ev_base_lower = 1'b0;
  logic        ev_uf_upper = 1'b0;
  logic        ev_uf_lower = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  // model: bit4 berr, bit3 vcmp, bit2 base, bit1 underflow, in word positions
  logic [31:0] m_stat = '0;
  logic [31:0] m_rdata = '0;

  always #2 clk = ~clk;

  disp_irq_unit dut_i (
    .clk(clk), .rst(rst), .ev_bus_err(ev_bus_err), .rgn_start(rgn_start),
    .rgn_sel(rgn_sel), .ev_base_upper(ev_base_upper), .ev_base_lower(ev_base_lower),
    .ev_uf_upper(ev_uf_upper), .ev_uf_lower(ev_uf_lower), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk32(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_bus_err = 0; rgn_start = '0; ev_base_upper = 0; ev_base_lower = 0;
    ev_uf_upper = 0; ev_uf_lower = 0; reg_wr = 0; reg_rd = 0;
    reg_addr = 8'h20; reg_wdata = '0;
  endtask

  // one clock: model update at the edge, compare at the following negedge
  task automatic tick(string tag);
    logic [31:0] setw, clrw;
    @(posedge clk);
    if (rst) begin
      m_stat = '0; m_rdata = '0;
    end else begin
      m_rdata = (reg_rd && reg_addr == 8'h20) ? m_stat : 32'h0;
      setw = '0;
      setw[4] = ev_bus_err;
      setw[3] = rgn_start[rgn_sel];
      setw[2] = ev_base_upper | ev_base_lower;
      setw[1] = ev_uf_upper | ev_uf_lower;
      clrw = (reg_wr && reg_addr == 8'h20) ? (reg_wdata & 32'h1E) : 32'h0;
      m_stat = (m_stat & ~clrw) | setw;
    end
    @(negedge clk);
    chk32({tag, " rdata"}, reg_rdata, m_rdata);
    chk32({"R10 irq (", tag, ")"}, {31'b0, irq}, {31'b0, m_stat != 0});
    idle_inputs();
  endtask

  task automatic rd_status(string tag, logic [31:0] exp);
    reg_rd = 1; reg_addr = 8'h20;
    tick(tag);
    chk32({tag, " readback"}, reg_rdata, exp);
  endtask

  task automatic w1c(string tag, logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick(tag);
  endtask

  task automatic set_all(string tag);
    ev_bus_err = 1; rgn_start = 4'hF; ev_base_upper = 1; ev_uf_lower = 1;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) tick("R1");
    set_all("R1");                   // events during reset are dropped
    rst = 0;
    tick("R1");
    chk32("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd_status("R1", 32'h0);

    // R5: bus error sticks
    ev_bus_err = 1; tick("R5");
    repeat (5) tick("R5");
    rd_status("R5", 32'h10);
    w1c("R3", 8'h20, 32'h10);
    rd_status("R3", 32'h0);

    // R6: each select value against every region pulse
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 4; r++) begin
        rgn_sel = 2'(s); rgn_start = 4'(1 << r);
        tick("R6");
        rgn_sel = 2'(s);
        rd_status("R6", (r == s) ? 32'h08 : 32'h0);
        w1c("R6", 8'h20, 32'hFFFF_FFFF);
      end
    end

    // R7 and R8: each single source and both together
    ev_uf_upper = 1; tick("R7"); rd_status("R7", 32'h02); w1c("R7", 8'h20, 32'h02);
    ev_uf_lower = 1; tick("R7"); rd_status("R7", 32'h02); w1c("R7", 8'h20, 32'h02);
    ev_uf_upper = 1; ev_uf_lower = 1; tick("R7"); rd_status("R7", 32'h02);
    w1c("R7", 8'h20, 32'h02);
    ev_base_upper = 1; tick("R8"); rd_status("R8", 32'h04); w1c("R8", 8'h20, 32'h04);
    ev_base_lower = 1; tick("R8"); rd_status("R8", 32'h04); w1c("R8", 8'h20, 32'h04);

    // R3 and R4: partial clears, zero writes, wrong offset, reserved bits
    set_all("R3");
    rd_status("R3", 32'h1E);
    w1c("R3", 8'h20, 32'h0);
    rd_status("R3", 32'h1E);
    w1c("R3", 8'h24, 32'hFFFF_FFFF);
    w1c("R3", 8'h00, 32'hFFFF_FFFF);
    rd_status("R3", 32'h1E);
    w1c("R4", 8'h20, 32'hFFFF_FFE1);
    rd_status("R4", 32'h1E);
    w1c("R3", 8'h20, 32'h04);
    rd_status("R3", 32'h1A);

    // R2: read at wrong offset gives 0, back-to-back reads
    reg_rd = 1; reg_addr = 8'h1C; tick("R2");
    chk32("R2 miss", reg_rdata, 32'h0);
    rd_status("R2", 32'h1A);
    rd_status("R2", 32'h1A);
    tick("R2");
    chk32("R2 no strobe", reg_rdata, 32'h0);

    // R9: set and clear same cycle on the same bit
    ev_bus_err = 1; reg_wr = 1; reg_addr = 8'h20; reg_wdata = 32'h1E;
    tick("R9");
    rd_status("R9", 32'h10);
    ev_uf_upper = 1; reg_wr = 1; reg_addr = 8'h20; reg_wdata = 32'h12;
    tick("R9");
    rd_status("R9", 32'h02);
    w1c("R10", 8'h20, 32'h1E);
    chk32("R10 irq low after clear", {31'b0, irq}, 32'h0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      ev_bus_err    = ($urandom_range(0, 15) == 0);
      rgn_start     = 4'($urandom) & 4'($urandom) & 4'($urandom);
      rgn_sel       = 2'($urandom);
      ev_base_upper = ($urandom_range(0, 11) == 0);
      ev_base_lower = ($urandom_range(0, 11) == 0);
      ev_uf_upper   = ($urandom_range(0, 11) == 0);
      ev_uf_lower   = ($urandom_range(0, 11) == 0);
      reg_rd        = ($urandom_range(0, 1) == 0);
      reg_wr        = ($urandom_range(0, 3) == 0);
      reg_addr      = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h20;
      reg_wdata     = $urandom;
      tick("R2");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule